// File: doc/BRIEF.md
# Serial Character Transmitter with Idle Queueing

This block turns 8-bit or 9-bit words into asynchronous serial frames on a single line. A one-entry holding register takes each word written by the host. The word moves into a shift register as soon as the previous frame ends. Every serial bit lasts sixteen pulses of an externally generated bit-rate tick, so baud generation stays outside the block.

Besides data frames, the engine sends two special characters. An idle character is a full character length of marks. A break character is a full character length of spaces. An idle character goes out as a preamble each time the transmitter is switched on. Switching the enable off and back on while a frame is shifting queues one extra idle character behind that frame. An invert control flips the polarity of everything on the line.

Two flags report progress, and each has its own interrupt enable. The empty flag says the holding register can take another word. The complete flag says nothing is left to send.

Top module: `serialTx`

## Requirements
- R1: Each serial bit is held for exactly 16 tick pulses. A data frame is sent LSB first: one start bit at 0, then 8 data bits (format select 0, using wrData[7:0]) or 9 data bits (format select 1, using wrData[8:0]), then one stop bit at 1.
- R2: On a 0-to-1 change of the enable, one idle character is sent before any break or data frame. The idle character is all 1s for 10 bit times in 8-bit format and 11 bit times in 9-bit format.
- R3: When the enable is cleared during a frame, that frame finishes. The line then rests at the idle level, and no new frame starts while the enable stays low.
- R4: Clearing and then setting the enable while a frame is shifting sends exactly one idle character immediately after that frame. Any waiting data follows the idle character.
- R5: With invert at 1, the line carries the complement of every level: idle, break, start, data and stop bits.
- R6: The empty flag is 1 after reset and sets when the holding register word moves into the shift register. A write clears it in the next cycle. emptyIrq is the flag gated by emptyIrqEn.
- R7: The complete flag is 1 only when the shift register is idle, the holding register is empty, no idle character is pending and no break is requested while enabled. A write clears it in the next cycle. doneIrq is the flag gated by doneIrqEn.
- R8: While sendBreak is 1 and the transmitter is enabled, break characters are sent: a start bit, 8 or 9 data bits and the stop position, all at 0. When a break is directly followed by an idle character, its stop position still lasts a whole bit time.
- R9: A write while the holding register is full replaces its contents. Only the last word written is sent.
- R10: When several things wait at a frame boundary, the order is: a pending idle character first, then a break, then held data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Transmitter enable |
| nineBit | input | 1 | Format select: 1 for 9 data bits, 0 for 8 |
| invert | input | 1 | Output polarity inversion |
| sendBreak | input | 1 | Request break characters |
| tick | input | 1 | Bit-rate tick, 16 per serial bit |
| wrStrobe | input | 1 | Holding register write strobe |
| wrData | input | 9 | Word to transmit |
| emptyIrqEn | input | 1 | Empty interrupt enable |
| doneIrqEn | input | 1 | Complete interrupt enable |
| txLine | output | 1 | Serial output line |
| emptyFlag | output | 1 | Holding register empty |
| doneFlag | output | 1 | Transmission complete |
| emptyIrq | output | 1 | Gated empty interrupt |
| doneIrq | output | 1 | Gated complete interrupt |

## Verification
The line-stability property assumes that the tick is the only thing that advances a running frame. It also assumes that invert changes only when the bench sets it, so it allows for a change in polarity. The stimulus drives every input half a cycle away from the sampling edge. It changes format select only while the engine is quiet, so that every frame length is well defined. The flag properties assume that a write is a one-cycle strobe. The bench writes either on single cycles or on back-to-back cycles while a frame is active, so the overwrite path is hit deliberately.

// File: rtl/txPkg.sv
package txPkg;
  typedef enum logic [1:0] {FR_IDLE, FR_BREAK, FR_DATA} frameKindT;

  typedef struct packed {
    logic      load;
    frameKindT kind;
  } txStrobeT;
endpackage

// File: rtl/txDatapath.sv
module txDatapath
  import txPkg::*;
#(
  parameter int DATA_W = 9,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              nineBit,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  txStrobeT          strobe,
  output logic              holdFull,
  output logic              busy,
  output logic              frameEnd,
  output logic              lineBit
);
  localparam int FRAME_MAX = DATA_W + 2;
  localparam int CNT_W = $clog2(TICKS_PER_BIT);
  localparam int BIT_CNT_W = $clog2(FRAME_MAX + 1);

  logic [DATA_W-1:0]    holdData;
  logic [FRAME_MAX-1:0] shiftReg, loadVec;
  logic [CNT_W-1:0]     tickCnt;
  logic [BIT_CNT_W-1:0] bitsLeft, frameLen;
  logic                 lastTick;

  // holding register: a write always wins over a transfer in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdData <= '0;
      holdFull <= 1'b0;
    end else if (wrStrobe) begin
      holdData <= wrData;
      holdFull <= 1'b1;
    end else if (strobe.load && strobe.kind == FR_DATA) begin
      holdFull <= 1'b0;
    end
  end

  // frame image, bit 0 leaves first
  always_comb begin
    frameLen = nineBit ? BIT_CNT_W'(FRAME_MAX) : BIT_CNT_W'(FRAME_MAX - 1);
    unique case (strobe.kind)
      FR_IDLE:  loadVec = {FRAME_MAX{1'b1}};
      FR_BREAK: loadVec = '0;
      default:  loadVec = nineBit ? {1'b1, holdData, 1'b0}
                                  : {2'b11, holdData[DATA_W-2:0], 1'b0};
    endcase
  end

  assign lastTick = tick && (tickCnt == CNT_W'(TICKS_PER_BIT - 1));
  assign frameEnd = busy && lastTick && (bitsLeft == BIT_CNT_W'(1));
  assign lineBit  = busy ? shiftReg[0] : 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '1;
      bitsLeft <= '0;
      tickCnt  <= '0;
      busy     <= 1'b0;
    end else if (strobe.load) begin
      shiftReg <= loadVec;
      bitsLeft <= frameLen;
      tickCnt  <= '0;
      busy     <= 1'b1;
    end else if (busy && tick) begin
      if (lastTick) begin
        tickCnt <= '0;
        if (bitsLeft == BIT_CNT_W'(1)) begin
          busy <= 1'b0;
        end else begin
          shiftReg <= {1'b1, shiftReg[FRAME_MAX-1:1]};
          bitsLeft <= bitsLeft - 1'b1;
        end
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/txControl.sv
module txControl
  import txPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  logic     sendBreak,
  input  logic     wrStrobe,
  input  logic     holdFull,
  input  logic     busy,
  input  logic     frameEnd,
  output txStrobeT strobe,
  output logic     emptyFlag,
  output logic     doneFlag
);
  logic enPrev, idlePending, enRise, pendIdle, canStart, dataLoad, idleLoad;

  assign enRise   = enable && !enPrev;
  assign pendIdle = idlePending || enRise;
  assign canStart = (!busy || frameEnd) && enable;

  // priority: queued idle, then break, then held data
  always_comb begin
    strobe.load = canStart && (pendIdle || sendBreak || holdFull);
    if (pendIdle)       strobe.kind = FR_IDLE;
    else if (sendBreak) strobe.kind = FR_BREAK;
    else                strobe.kind = FR_DATA;
  end

  assign dataLoad = strobe.load && strobe.kind == FR_DATA;
  assign idleLoad = strobe.load && strobe.kind == FR_IDLE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev      <= 1'b0;
      idlePending <= 1'b0;
      emptyFlag   <= 1'b1;
      doneFlag    <= 1'b1;
    end else begin
      enPrev      <= enable;
      idlePending <= pendIdle && !idleLoad;
      if (wrStrobe)      emptyFlag <= 1'b0;
      else if (dataLoad) emptyFlag <= 1'b1;
      doneFlag <= !wrStrobe && !busy && !holdFull && !pendIdle
                  && !(enable && sendBreak);
    end
  end
endmodule

// File: rtl/serialTx.sv
module serialTx
  import txPkg::*;
#(
  parameter int DATA_W = 9,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              nineBit,
  input  logic              invert,
  input  logic              sendBreak,
  input  logic              tick,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              emptyIrqEn,
  input  logic              doneIrqEn,
  output logic              txLine,
  output logic              emptyFlag,
  output logic              doneFlag,
  output logic              emptyIrq,
  output logic              doneIrq
);
  txStrobeT strobe;
  logic     holdFull, busy, frameEnd, lineBit;

  txControl i_txControl (
    .clk(clk), .rstN(rstN), .enable(enable), .sendBreak(sendBreak),
    .wrStrobe(wrStrobe), .holdFull(holdFull), .busy(busy),
    .frameEnd(frameEnd), .strobe(strobe), .emptyFlag(emptyFlag),
    .doneFlag(doneFlag)
  );

  txDatapath #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) i_txDatapath (
    .clk(clk), .rstN(rstN), .tick(tick), .nineBit(nineBit),
    .wrStrobe(wrStrobe), .wrData(wrData), .strobe(strobe),
    .holdFull(holdFull), .busy(busy), .frameEnd(frameEnd), .lineBit(lineBit)
  );

  assign txLine   = lineBit ^ invert;
  assign emptyIrq = emptyFlag && emptyIrqEn;
  assign doneIrq  = doneFlag && doneIrqEn;
endmodule

// File: rtl/txChecker.sv
module txChecker
  import txPkg::*;
(
  input logic     clk,
  input logic     rstN,
  input logic     tick,
  input logic     invert,
  input logic     wrStrobe,
  input logic     txLine,
  input logic     emptyFlag,
  input logic     doneFlag,
  input logic     busy,
  input logic     holdFull,
  input txStrobeT strobe
);
  // R3: with no frame active the line sits at the (possibly inverted) mark level
  p_rest_level_r3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (txLine == !invert));

  // R1: a running frame only changes level on a tick
  p_hold_between_ticks_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !tick) |=> ($stable(txLine) || !$stable(invert)));

  // R6: a write clears the empty flag in the next cycle
  p_write_clears_empty_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !emptyFlag);

  // R6: the empty flag only rises after a data transfer
  p_empty_on_transfer_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(emptyFlag) |-> $past(strobe.load && strobe.kind == FR_DATA));

  // R7: complete implies both registers were empty one cycle earlier
  p_done_needs_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |-> $past(!holdFull && !busy));

  // R7: a write clears the complete flag in the next cycle
  p_write_clears_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !doneFlag);
endmodule

bind serialTx txChecker i_txChecker (
  .clk(clk), .rstN(rstN), .tick(tick), .invert(invert), .wrStrobe(wrStrobe),
  .txLine(txLine), .emptyFlag(emptyFlag), .doneFlag(doneFlag), .busy(busy),
  .holdFull(holdFull), .strobe(strobe)
);

// File: tb/test_serialTx.sv
`timescale 1ns/1ps
module test_serialTx;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, nineBit = 1'b0, invert = 1'b0, sendBreak = 1'b0;
  logic tick = 1'b0, wrStrobe = 1'b0, emptyIrqEn = 1'b1, doneIrqEn = 1'b1;
  logic [8:0] wrData = '0;
  logic txLine, emptyFlag, doneFlag, emptyIrq, doneIrq;

  int checks = 0, failures = 0;
  string curReq = "R6";
  bit finished = 0;
  int tickMode = 0;
  int tickPhase = 0;

  serialTx i_serialTx (
    .clk(clk), .rstN(rstN), .enable(enable), .nineBit(nineBit),
    .invert(invert), .sendBreak(sendBreak), .tick(tick),
    .wrStrobe(wrStrobe), .wrData(wrData), .emptyIrqEn(emptyIrqEn),
    .doneIrqEn(doneIrqEn), .txLine(txLine), .emptyFlag(emptyFlag),
    .doneFlag(doneFlag), .emptyIrq(emptyIrq), .doneIrq(doneIrq)
  );

  always #2 clk = ~clk;

  // tick: every cycle (mode 0) or every third cycle (mode 1)
  always @(negedge clk) begin
    tickPhase++;
    tick <= (tickMode == 0) || (tickPhase % 3 == 0);
  end

  // behavioural reference: a queue of pending line bits per frame
  int  bq[$];
  bit  mBusy = 0, mFull = 0, mEmpty = 1, mDone = 1, mPend = 0, mEnPrev = 0;
  int  mTicks = 0, mHold = 0;

  task automatic buildFrame(input int kind);
    int n = nineBit ? 11 : 10;
    int nb = nineBit ? 9 : 8;
    bq.delete();
    if (kind == 0) for (int i = 0; i < n; i++) bq.push_back(1);
    else if (kind == 1) for (int i = 0; i < n; i++) bq.push_back(0);
    else begin
      bq.push_back(0);
      for (int i = 0; i < nb; i++) bq.push_back((mHold >> i) & 1);
      bq.push_back(1);
    end
  endtask

  task automatic check(input bit act, input bit exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%0b exp=%0b at %0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bq.delete(); mBusy = 0; mFull = 0; mEmpty = 1; mDone = 1; mPend = 0;
      mEnPrev = 0; mTicks = 0; mHold = 0;
    end else begin
      bit rise, pend, endNow, start, doneNext;
      int kind;
      rise = enable && !mEnPrev;
      pend = mPend || rise;
      endNow = mBusy && tick && mTicks == 15 && bq.size() == 1;
      start = (!mBusy || endNow) && enable && (pend || sendBreak || mFull);
      kind = pend ? 0 : (sendBreak ? 1 : 2);
      doneNext = !wrStrobe && !mBusy && !mFull && !pend && !(enable && sendBreak);
      if (wrStrobe) mEmpty = 0;
      else if (start && kind == 2) mEmpty = 1;
      if (start) begin
        buildFrame(kind); mTicks = 0; mBusy = 1;
      end else if (mBusy && tick) begin
        if (mTicks == 15) begin
          mTicks = 0;
          if (bq.size() == 1) begin mBusy = 0; bq.delete(); end
          else void'(bq.pop_front());
        end else mTicks++;
      end
      if (wrStrobe) begin mHold = wrData; mFull = 1; end
      else if (start && kind == 2) mFull = 0;
      mPend = pend && !(start && kind == 0);
      mEnPrev = enable;
      mDone = doneNext;
      #1;
      check(txLine, (mBusy ? bq[0][0] : 1'b1) ^ invert, "txLine");
      check(emptyFlag, mEmpty, "emptyFlag");
      check(doneFlag, mDone, "doneFlag");
      check(emptyIrq, mEmpty && emptyIrqEn, "emptyIrq");
      check(doneIrq, mDone && doneIrqEn, "doneIrq");
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(input int d);
    @(negedge clk); wrStrobe = 1; wrData = 9'(d);
    @(negedge clk); wrStrobe = 0;
  endtask

  task automatic waitQuiet();
    do @(negedge clk); while (mBusy || mFull || mPend);
    cyc(3);
  endtask

  initial begin
    cyc(3);
    curReq = "R6";
    check(txLine, 1'b1, "reset line");
    check(emptyFlag, 1'b1, "reset empty");
    curReq = "R7";
    check(doneFlag, 1'b1, "reset done");
    rstN = 1;
    cyc(2);
    // preamble, then an 8-bit frame
    curReq = "R2"; enable = 1; cyc(3);
    curReq = "R1"; write(9'h0A5); waitQuiet();
    // 9-bit frames with an overwrite of the holding register
    curReq = "R9"; nineBit = 1; write(9'h1C3); cyc(3);
    write(9'h0F0); write(9'h155); waitQuiet();
    // toggle while shifting queues one idle
    curReq = "R4"; nineBit = 0; write(9'h03C); cyc(40);
    enable = 0; cyc(2); enable = 1; write(9'h081); waitQuiet();
    // enable dropped mid-frame: frame completes, held word waits
    curReq = "R3"; write(9'h066); cyc(30); enable = 0; write(9'h099); cyc(400);
    enable = 1; waitQuiet();
    // break followed directly by an idle character, slower tick
    curReq = "R8"; tickMode = 1; sendBreak = 1; cyc(200);
    sendBreak = 0; enable = 0; cyc(2); enable = 1; waitQuiet();
    // inverted line, interrupt gating
    curReq = "R5"; tickMode = 0; invert = 1; emptyIrqEn = 0;
    write(9'h05A); cyc(5); write(9'h0C3); waitQuiet();
    doneIrqEn = 0; cyc(5); emptyIrqEn = 1; cyc(5); invert = 0; cyc(3);
    // ordering: idle, break, data all waiting at once
    curReq = "R10"; doneIrqEn = 1; enable = 0; cyc(2);
    sendBreak = 1; write(9'h012); enable = 1; cyc(200); sendBreak = 0;
    waitQuiet();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog %s act=running exp=finished", curReq);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule